// File: doc/BRIEF.md
# Compressed Immediate-Instruction Expander

This block turns a 16-bit compressed instruction from the quadrant whose low two bits are `01` into the 32-bit base instruction it stands for. It handles only the register-immediate group:

- add-immediate;
- add-immediate-word;
- stack-pointer adjust;
- load-upper-immediate;
- the no-op and its hint variants.

It sits in the fetch path in front of a 32-bit decoder. Each strobed input produces a registered result one clock later.

Alongside the expanded word, the block reports two flags. The illegal flag marks reserved or unsupported encodings. The hint flag marks encodings that target register x0 and must execute as harmless no-ops. The stack-adjust immediate is stored in a shuffled bit order in the compressed form, and the block puts it back together before building the base instruction. An RV64 mode input decides whether the add-immediate-word form exists.

Input fields used below: `cin[15:13]` is the group selector, `cin[12]` is immediate bit 5, `cin[11:7]` is the destination, `cin[6:2]` holds immediate bits 4:0, and `cin[1:0]` is the quadrant.

Top module: `cq1_expander`

## Requirements
- R1: Selector `000` with destination d≠0 yields `addi xd, xd, sext(imm6)`, where imm6 = {cin[12], cin[6:2]}. The result uses opcode `0010011` and funct3 `000`; the illegal and hint flags stay low.
- R2: Selector `000` with destination 0 yields `addi x0, x0, sext(imm6)`, with the hint flag high and the illegal flag low. This holds for both zero and non-zero imm6.
- R3: Selector `001` in RV64 mode with d≠0 yields `addiw xd, xd, sext(imm6)`, with opcode `0011011` and funct3 `000`. A zero immediate is accepted.
- R4: Selector `001` with RV64 mode low, or with destination 0, is illegal.
- R5: Selector `011` with destination 2 and a non-zero immediate yields `addi x2, x2, sext(nz)`. Here nz is a 10-bit value with nz[9]=cin[12], nz[4]=cin[6], nz[6]=cin[5], nz[8:7]=cin[4:3], nz[5]=cin[2] and nz[3:0]=0.
- R6: Selector `011` with a destination other than 0 or 2 and a non-zero imm6 yields `lui xd, U`. U (20 bits) is imm6 sign-extended, and the opcode is `0110111`.
- R7: Selector `011` with a zero imm6 is illegal, whatever the destination.
- R8: Selector `011` with destination 0 and a non-zero imm6 yields `lui x0, U`, with the hint flag high.
- R9: Quadrant bits other than `01`, or a selector outside {`000`,`001`,`011`}, set the illegal flag. Every illegal result drives an all-zero expanded word.
- R10: The output valid equals the input valid of the previous clock, and the result belongs to the instruction that was strobed then.
- R11: A cycle with input valid low leaves the expanded word unchanged and drives the illegal and hint flags low.
- R12: Synchronous active-high reset clears the output valid, illegal and hint flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cin_valid | input | 1 | Input instruction strobe |
| cin | input | 16 | Compressed instruction |
| rv64 | input | 1 | RV64 mode enable |
| xout_valid | output | 1 | Result strobe, one cycle after the input strobe |
| xout | output | 32 | Expanded 32-bit instruction |
| xout_illegal | output | 1 | Reserved or unsupported encoding |
| xout_hint | output | 1 | Hint encoding writing x0 |

## Verification
The bench places single bits into each slot of the shuffled stack-adjust immediate. A design that kept the field in source order would put 16, 32, 64, 128 or 256 into the wrong immediate bit. The bench also feeds the add-immediate-word selector with RV64 mode low. A design that decoded it anyway would emit an `addiw` word where an illegal flag is required. Zero-immediate stack-adjust and load-upper forms, and no-op/hint encodings with destination x0, are applied as well. These expose a design that flags hints as illegal, or that lets a zero load-upper or stack adjust through as a legal instruction. Idle cycles between strobes show whether stale flags are held.

// File: rtl/cq1_pkg.sv
package cq1_pkg;
    localparam int CLEN = 16;
    localparam int ILEN = 32;
    localparam int RLEN = 5;

    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
    localparam logic [6:0] OPC_LUI     = 7'b0110111;

    localparam logic [2:0] SEL_ADD  = 3'b000;
    localparam logic [2:0] SEL_ADDW = 3'b001;
    localparam logic [2:0] SEL_UPR  = 3'b011;
    localparam logic [1:0] QUAD1    = 2'b01;
    localparam logic [RLEN-1:0] REG_SP = 5'd2;

    typedef enum logic [2:0] {
        K_BAD,
        K_ADDI,
        K_ADDIW,
        K_SPADJ,
        K_LUI,
        K_NOPHINT,
        K_LUIHINT
    } kind_e;
endpackage

// File: rtl/cq1_classify.sv
module cq1_classify
    import cq1_pkg::*;
(
    input  logic [CLEN-1:0] ci,
    input  logic            rv64,
    output kind_e           kind
);
    logic [2:0]      sel;
    logic [RLEN-1:0] rd;
    logic            imm_zero;

    assign sel      = ci[15:13];
    assign rd       = ci[11:7];
    assign imm_zero = ({ci[12], ci[6:2]} == 6'd0);

    always_comb begin
        kind = K_BAD;
        if (ci[1:0] == QUAD1) begin
            unique case (sel)
                SEL_ADD:  kind = (rd == '0) ? K_NOPHINT : K_ADDI;
                SEL_ADDW: kind = (rv64 && rd != '0) ? K_ADDIW : K_BAD;
                SEL_UPR: begin
                    if (imm_zero)            kind = K_BAD;
                    else if (rd == REG_SP)   kind = K_SPADJ;
                    else if (rd == '0)       kind = K_LUIHINT;
                    else                     kind = K_LUI;
                end
                default:  kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/cq1_format.sv
module cq1_format
    import cq1_pkg::*;
(
    input  logic [CLEN-1:0] ci,
    input  kind_e           kind,
    output logic [ILEN-1:0] word,
    output logic            ill,
    output logic            hint
);
    logic [RLEN-1:0] rd;
    logic [11:0]     imm_i;
    logic [11:0]     imm_sp;
    logic [19:0]     imm_u;

    assign rd     = ci[11:7];
    assign imm_i  = {{6{ci[12]}}, ci[12], ci[6:2]};
    // shuffled field: bit12=n9, b6=n4, b5=n6, b4:3=n8:7, b2=n5
    assign imm_sp = {{2{ci[12]}}, ci[12], ci[4], ci[3], ci[5], ci[2], ci[6], 4'b0000};
    assign imm_u  = {{14{ci[12]}}, ci[12], ci[6:2]};

    always_comb begin
        word = '0;
        ill  = 1'b0;
        hint = 1'b0;
        unique case (kind)
            K_ADDI:    word = {imm_i, rd, 3'b000, rd, OPC_OPIMM};
            K_NOPHINT: begin
                word = {imm_i, 5'd0, 3'b000, 5'd0, OPC_OPIMM};
                hint = 1'b1;
            end
            K_ADDIW:   word = {imm_i, rd, 3'b000, rd, OPC_OPIMM32};
            K_SPADJ:   word = {imm_sp, REG_SP, 3'b000, REG_SP, OPC_OPIMM};
            K_LUI:     word = {imm_u, rd, OPC_LUI};
            K_LUIHINT: begin
                word = {imm_u, 5'd0, OPC_LUI};
                hint = 1'b1;
            end
            default:   ill = 1'b1;
        endcase
    end
endmodule

// File: rtl/cq1_expander.sv
module cq1_expander
    import cq1_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cin_valid,
    input  logic [CLEN-1:0] cin,
    input  logic            rv64,
    output logic            xout_valid,
    output logic [ILEN-1:0] xout,
    output logic            xout_illegal,
    output logic            xout_hint
);
    kind_e           kind;
    logic [ILEN-1:0] word_d;
    logic            ill_d;
    logic            hint_d;

    cq1_classify u_cls (
        .ci   (cin),
        .rv64 (rv64),
        .kind (kind)
    );

    cq1_format u_fmt (
        .ci   (cin),
        .kind (kind),
        .word (word_d),
        .ill  (ill_d),
        .hint (hint_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xout_valid   <= 1'b0;
            xout_illegal <= 1'b0;
            xout_hint    <= 1'b0;
            xout         <= '0;
        end else begin
            xout_valid   <= cin_valid;
            xout_illegal <= cin_valid & ill_d;
            xout_hint    <= cin_valid & hint_d;
            if (cin_valid) xout <= word_d;
        end
    end

    // R10: strobe follows input one clock later
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (xout_valid == $past(cin_valid)));
    // R9: illegal results carry a zero word
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        xout_illegal |-> (xout == '0));
    // R2/R8: hints write x0 only
    a_r2_hint_x0: assert property (@(posedge clk) disable iff (rst)
        xout_hint |-> (xout[11:7] == 5'd0));
    // R9: never both illegal and hint
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(xout_illegal && xout_hint));
    // R11: flags only with a valid result
    a_r11_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        !xout_valid |-> (!xout_illegal && !xout_hint));
    // R11: word held across idle cycles
    a_r11_word_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cin_valid)) |-> $stable(xout));
endmodule

// File: tb/tb_cq1_expander.sv
`timescale 1ns/1ps
module tb_cq1_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cin_valid = 1'b0;
    logic [15:0] cin = '0;
    logic        rv64 = 1'b0;
    logic        xout_valid;
    logic [31:0] xout;
    logic        xout_illegal;
    logic        xout_hint;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cq1_expander dut (
        .clk(clk), .rst(rst), .cin_valid(cin_valid), .cin(cin), .rv64(rv64),
        .xout_valid(xout_valid), .xout(xout),
        .xout_illegal(xout_illegal), .xout_hint(xout_hint)
    );

    function automatic logic [15:0] ci(input logic [2:0] sel, input logic b12,
                                       input logic [4:0] rd, input logic [4:0] lo,
                                       input logic [1:0] q);
        return {sel, b12, rd, lo, q};
    endfunction

    function automatic logic [31:0] itype(input logic [11:0] imm, input logic [4:0] rs,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {imm, rs, 3'b000, rd, opc};
    endfunction

    task automatic chk(input string req, input logic v, input logic [31:0] w,
                       input logic il, input logic h);
        n_chk++;
        if (xout_valid !== v || xout !== w || xout_illegal !== il || xout_hint !== h) begin
            n_bad++;
            $display("FAIL %s: got v=%b w=%h ill=%b hint=%b, expected v=%b w=%h ill=%b hint=%b",
                     req, xout_valid, xout, xout_illegal, xout_hint, v, w, il, h);
        end
    endtask

    task automatic apply(input logic [15:0] c, input logic m);
        @(negedge clk);
        cin = c; rv64 = m; cin_valid = 1'b1;
        @(negedge clk);
        cin_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 reset", 1'b0, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_addi;
        apply(ci(3'b000, 1'b0, 5'd5, 5'd7, 2'b01), 1'b0);
        chk("R1 addi +7", 1'b1, itype(12'd7, 5'd5, 5'd5, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b000, 1'b1, 5'd31, 5'd0, 2'b01), 1'b1);
        chk("R1 addi -32", 1'b1, itype(12'hFE0, 5'd31, 5'd31, 7'b0010011), 1'b0, 1'b0);
    endtask

    task automatic t_nop_hint;
        apply(ci(3'b000, 1'b0, 5'd0, 5'd0, 2'b01), 1'b0);
        chk("R2 nop", 1'b1, itype(12'd0, 5'd0, 5'd0, 7'b0010011), 1'b0, 1'b1);
        apply(ci(3'b000, 1'b1, 5'd0, 5'd3, 2'b01), 1'b0);
        chk("R2 hint", 1'b1, itype(12'hFE3, 5'd0, 5'd0, 7'b0010011), 1'b0, 1'b1);
    endtask

    task automatic t_addiw;
        apply(ci(3'b001, 1'b0, 5'd9, 5'd0, 2'b01), 1'b1);
        chk("R3 addiw zero", 1'b1, itype(12'd0, 5'd9, 5'd9, 7'b0011011), 1'b0, 1'b0);
        apply(ci(3'b001, 1'b1, 5'd9, 5'd31, 2'b01), 1'b1);
        chk("R3 addiw -1", 1'b1, itype(12'hFFF, 5'd9, 5'd9, 7'b0011011), 1'b0, 1'b0);
        apply(ci(3'b001, 1'b0, 5'd9, 5'd4, 2'b01), 1'b0);
        chk("R4 addiw rv32", 1'b1, 32'h0, 1'b1, 1'b0);
        apply(ci(3'b001, 1'b0, 5'd0, 5'd4, 2'b01), 1'b1);
        chk("R4 addiw rd0", 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_spadj;
        apply(ci(3'b011, 1'b0, 5'd2, 5'b10000, 2'b01), 1'b0);
        chk("R5 sp +16", 1'b1, itype(12'd16, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd2, 5'b00001, 2'b01), 1'b0);
        chk("R5 sp +32", 1'b1, itype(12'd32, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd2, 5'b01000, 2'b01), 1'b0);
        chk("R5 sp +64", 1'b1, itype(12'd64, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd2, 5'b00010, 2'b01), 1'b0);
        chk("R5 sp +128", 1'b1, itype(12'd128, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd2, 5'b00100, 2'b01), 1'b0);
        chk("R5 sp +256", 1'b1, itype(12'd256, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b1, 5'd2, 5'b00000, 2'b01), 1'b0);
        chk("R5 sp -512", 1'b1, itype(12'hE00, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b1, 5'd2, 5'b11111, 2'b01), 1'b0);
        chk("R5 sp -16", 1'b1, itype(12'hFF0, 5'd2, 5'd2, 7'b0010011), 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd2, 5'b00000, 2'b01), 1'b0);
        chk("R7 sp zero", 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_lui;
        apply(ci(3'b011, 1'b1, 5'd10, 5'b00001, 2'b01), 1'b0);
        chk("R6 lui neg", 1'b1, {20'hFFFE1, 5'd10, 7'b0110111}, 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd3, 5'b10101, 2'b01), 1'b0);
        chk("R6 lui pos", 1'b1, {20'h00015, 5'd3, 7'b0110111}, 1'b0, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd3, 5'b00000, 2'b01), 1'b0);
        chk("R7 lui zero", 1'b1, 32'h0, 1'b1, 1'b0);
        apply(ci(3'b011, 1'b0, 5'd0, 5'b00110, 2'b01), 1'b0);
        chk("R8 lui hint", 1'b1, {20'h00006, 5'd0, 7'b0110111}, 1'b0, 1'b1);
    endtask

    task automatic t_illegal;
        apply(ci(3'b000, 1'b0, 5'd5, 5'd7, 2'b10), 1'b1);
        chk("R9 quadrant", 1'b1, 32'h0, 1'b1, 1'b0);
        apply(ci(3'b010, 1'b0, 5'd5, 5'd7, 2'b01), 1'b1);
        chk("R9 selector 010", 1'b1, 32'h0, 1'b1, 1'b0);
        apply(ci(3'b101, 1'b0, 5'd5, 5'd7, 2'b01), 1'b1);
        chk("R9 selector 101", 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_timing_hold;
        logic [31:0] exp_w;
        exp_w = itype(12'd1, 5'd0, 5'd0, 7'b0010011);
        apply(ci(3'b000, 1'b0, 5'd0, 5'd1, 2'b01), 1'b0);
        chk("R10 strobe one cycle", 1'b1, exp_w, 1'b0, 1'b1);
        cin = ci(3'b011, 1'b0, 5'd2, 5'b00000, 2'b01);
        @(negedge clk);
        chk("R11 idle hold", 1'b0, exp_w, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 stays low", 1'b0, exp_w, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_addi();
        t_nop_hint();
        t_addiw();
        t_spadj();
        t_lui();
        t_illegal();
        t_timing_hold();
        apply(ci(3'b000, 1'b0, 5'd4, 5'd2, 2'b01), 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R12 reset after use", 1'b0, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule